// File: doc/BRIEF.md
# MCU-to-Raster Reorder Buffer

This block sits after the colour stage of a block-based image decoder and turns block-ordered pixel data into scan lines. Samples arrive one per beat, 8x8 block by 8x8 block. The three component blocks of each minimal coded unit come in turn, and the units run left to right along a row of the image. The block writes a complete row of units, which is eight image lines tall, into one of two strip stores. It then plays that strip out as eight full-width raster lines of RGB pixels while the other strip is being filled.

The image size is given as a width in units and a height in unit rows. Both are held stable for a whole frame. Only three-component data with no subsampling is handled, so each unit carries exactly three blocks. The width limit is set by a parameter.

Top module: `mcu_raster_reorder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Each accepted beat carries one 8-bit sample, and in_blk selects its component (0 = red, 1 = green, 2 = blue). Within a block the 64 samples come in row-major order, row 0 column 0 first. The blocks of a unit come in the order 0, 1, 2, and units run left to right across the row.
- R3: A strip is emitted as 8 lines, top line first. Each line holds cfg_w_mcu*8 pixels, left to right, for cfg_h_mcu*64*cfg_w_mcu pixels per frame. out_rgb packs red in [23:16], green in [15:8] and blue in [7:0].
- R4: out_sol is 1 on column 0 of every output line and 0 on every other pixel.
- R5: out_eof is 1 only on the last pixel of the last line of unit row cfg_h_mcu-1. The pixel after it starts a new frame and has out_sol set.
- R6: out_valid stays 0 until the last sample of a whole unit row has been accepted. It is 1 in the cycle after that sample.
- R7: in_ready is 0 while both strips hold unread data. It returns to 1 in the cycle after the last pixel of the strip being read is taken.
- R8: While out_valid is 1 and out_ready is 0, out_rgb, out_sol and out_eof hold their values.
- R9: While one full strip waits unread, the other strip can be filled without stalling (in_ready stays 1).
- R10: A beat presented while in_ready is 0 is not accepted and changes no stored pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_w_mcu | input | $clog2(MAX_W_MCU+1) | Image width in units (8 pixels each) |
| cfg_h_mcu | input | $clog2(MAX_H_MCU+1) | Image height in unit rows (8 lines each) |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample can be taken |
| in_blk | input | 2 | Block index within the unit, which is the component |
| in_sample | input | SW | Sample value |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Output pixel taken |
| out_rgb | output | 3*SW | Pixel, red in the top byte |
| out_sol | output | 1 | First pixel of a line |
| out_eof | output | 1 | Last pixel of the frame |

## Verification
The bench goes after the edges of the strip handshake. It checks that nothing appears one sample before a unit row completes; a design that released the strip early would show stale or half-written pixels. It fills both strips while the output is stalled and then offers extra samples. A design that ignored the full condition would overwrite the first strip, and those pixels would come out wrong. Frames with widths of one unit and of the maximum, with odd heights, and with output throttling check line wrap, the frame marker and the return to column 0. A wrong address split or a bad wrap would scramble columns or misplace out_sol and out_eof.

// File: rtl/mcu_raster_reorder.sv
module mcu_raster_reorder #(
  parameter int MAX_W_MCU = 16,
  parameter int MAX_H_MCU = 64,
  parameter int SW        = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(MAX_W_MCU+1)-1:0] cfg_w_mcu,
  input  logic [$clog2(MAX_H_MCU+1)-1:0] cfg_h_mcu,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [1:0]                     in_blk,
  input  logic [SW-1:0]                  in_sample,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [3*SW-1:0]                out_rgb,
  output logic                           out_sol,
  output logic                           out_eof
);
  localparam int MAXW  = MAX_W_MCU * 8;
  localparam int STRIP = 8 * MAXW;
  localparam int DEPTH = 2 * STRIP;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(MAX_W_MCU + 1);
  localparam int HW    = $clog2(MAX_H_MCU + 1);
  localparam int XW    = $clog2(MAXW);
  localparam int LW    = CW + 3;

  logic [1:0]    full;
  logic          wr_sel, rd_sel;
  logic [5:0]    smp;
  logic [CW-1:0] wr_mx;
  logic [XW-1:0] rd_x;
  logic [2:0]    rd_line;
  logic [HW-1:0] rd_row;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [LW-1:0] last_col;

  logic in_fire, out_fire, mcu_end, row_end, line_end, strip_end, frame_end;
  logic [1:0] set_m, clr_m;

  assign in_ready  = ~full[wr_sel];
  assign out_valid = full[rd_sel];
  assign in_fire   = in_valid & in_ready;
  assign out_fire  = out_valid & out_ready;

  assign mcu_end   = (smp == 6'd63) && (in_blk == 2'd2);
  assign row_end   = mcu_end && (wr_mx == cfg_w_mcu - 1'b1);
  assign last_col  = {cfg_w_mcu, 3'b000} - 1'b1;
  assign line_end  = (LW'(rd_x) == last_col);
  assign strip_end = line_end && (rd_line == 3'd7);
  assign frame_end = strip_end && (rd_row == cfg_h_mcu - 1'b1);

  assign out_sol = (rd_x == '0);
  assign out_eof = frame_end;

  assign wr_addr = AW'(wr_sel * STRIP + smp[5:3] * MAXW + wr_mx * 8 + smp[2:0]);
  assign rd_addr = AW'(rd_sel * STRIP + rd_line * MAXW + rd_x);

  assign set_m = (in_fire && row_end)    ? (2'b01 << wr_sel) : 2'b00;
  assign clr_m = (out_fire && strip_end) ? (2'b01 << rd_sel) : 2'b00;

  for (genvar c = 0; c < 3; c++) begin : g_plane
    logic [SW-1:0] mem [DEPTH];
    always_ff @(posedge clk)
      if (in_fire && in_blk == 2'(c)) mem[wr_addr] <= in_sample;
    assign out_rgb[(2-c)*SW +: SW] = mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= '0;
      wr_sel  <= 1'b0;
      rd_sel  <= 1'b0;
      smp     <= '0;
      wr_mx   <= '0;
      rd_x    <= '0;
      rd_line <= '0;
      rd_row  <= '0;
    end else begin
      full <= (full | set_m) & ~clr_m;
      if (in_fire) begin
        smp <= smp + 1'b1;
        if (mcu_end) wr_mx <= row_end ? '0 : wr_mx + 1'b1;
        if (row_end) wr_sel <= ~wr_sel;
      end
      if (out_fire) begin
        rd_x <= line_end ? '0 : rd_x + 1'b1;
        if (line_end) rd_line <= rd_line + 1'b1;
        if (strip_end) begin
          rd_sel <= ~rd_sel;
          rd_row <= frame_end ? '0 : rd_row + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mcu_raster_reorder_chk.sv
module mcu_raster_reorder_chk #(
  parameter int OW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_rgb,
  input logic          out_sol,
  input logic          out_eof
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> in_ready && !out_valid);

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_sol) && $stable(out_eof));

  assert_eof_not_sol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eof |-> !out_sol);

  assert_frame_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eof |=> !out_valid || out_sol);

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));

  assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));
endmodule

bind mcu_raster_reorder mcu_raster_reorder_chk #(.OW(3*SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
  .out_sol(out_sol), .out_eof(out_eof)
);

// File: tb/mcu_raster_reorder_tb_top.sv
`timescale 1ns/1ps
module mcu_raster_reorder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cfg_w_mcu = 5'd1;
  logic [6:0] cfg_h_mcu = 7'd1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_blk = 2'd0;
  logic [7:0] in_sample = 8'd0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [23:0] out_rgb;
  logic       out_sol, out_eof;

  int n_chk = 0, n_fail = 0, wd = 0, cyc = 0, pix_cnt = 0;

  always #5 clk = ~clk;

  mcu_raster_reorder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_w_mcu(cfg_w_mcu), .cfg_h_mcu(cfg_h_mcu),
    .in_valid(in_valid), .in_ready(in_ready), .in_blk(in_blk), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
    .out_sol(out_sol), .out_eof(out_eof)
  );

  localparam int NV = 5;
  localparam int VW[NV] = '{1, 2, 3, 16, 4};
  localparam int VH[NV] = '{1, 1, 2, 1, 3};
  localparam int VM[NV] = '{0, 1, 2, 0, 1};
  localparam int VG[NV] = '{0, 0, 1, 0, 1};
  localparam int VN[NV] = '{64, 128, 384, 1024, 768};

  always @(posedge clk) begin
    if (out_valid && out_ready) pix_cnt <= pix_cnt + 1;
    wd <= wd + 1;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles exp < 150000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] smpv(input int c, input int x, input int y, input int fr);
    return 8'((x * 5 + y * 11 + c * 77 + fr * 29) & 255);
  endfunction

  task automatic push(input int c, input logic [7:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_blk = 2'(c); in_sample = v;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // R2: one unit row, blocks 0,1,2 per unit, samples row-major
  task automatic push_row(input int w, input int mr, input int fr, input int gap, input bit short_end);
    for (int mx = 0; mx < w; mx++)
      for (int c = 0; c < 3; c++)
        for (int s = 0; s < 64; s++) begin
          if (!(short_end && mx == w - 1 && c == 2 && s == 63)) begin
            if (gap != 0 && s % 5 == 0) @(negedge clk);
            push(c, smpv(c, mx * 8 + s % 8, mr * 8 + s / 8, fr));
          end
        end
  endtask

  task automatic recv_rows(input int w, input int h, input int fr, input int mode, input int y0, input int y1);
    bit stalled = 1'b0;
    logic [25:0] held = '0;
    for (int y = y0; y < y1; y++)
      for (int x = 0; x < w * 8; x++) begin
        logic [23:0] exp;
        forever begin
          @(negedge clk);
          cyc++;
          out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? 1'(cyc % 2) : 1'(cyc % 3 == 0);
          if (stalled && out_valid)
            chk({out_rgb, out_sol, out_eof} == held, "R8 hold", 32'({out_rgb, out_sol, out_eof}), 32'(held));
          stalled = out_valid && !out_ready;
          held = {out_rgb, out_sol, out_eof};
          if (out_valid && out_ready) break;
        end
        exp = {smpv(0, x, y, fr), smpv(1, x, y, fr), smpv(2, x, y, fr)};
        chk(out_rgb == exp, "R3 R2 pixel", 32'(out_rgb), 32'(exp));
        chk(out_sol == (x == 0), "R4 sol", 32'(out_sol), 32'(x == 0));
        chk(out_eof == (y == h * 8 - 1 && x == w * 8 - 1), "R5 eof", 32'(out_eof),
            32'(y == h * 8 - 1 && x == w * 8 - 1));
      end
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  initial begin
    int fr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);

    for (int v = 0; v < NV; v++) begin
      int start;
      fr++;
      cfg_w_mcu = 5'(VW[v]); cfg_h_mcu = 7'(VH[v]);
      start = pix_cnt;
      fork
        for (int r = 0; r < VH[v]; r++) push_row(VW[v], r, fr, VG[v], 1'b0);
        recv_rows(VW[v], VH[v], fr, VM[v], 0, VH[v] * 8);
      join
      @(negedge clk);
      chk(pix_cnt - start == VN[v], "R3 pixel count", 32'(pix_cnt - start), 32'(VN[v]));
      chk(out_valid == 1'b0, "R6 idle after frame", 32'(out_valid), 32'd0);
    end

    // R6: strip held back until the final sample of the unit row
    fr++;
    cfg_w_mcu = 5'd2; cfg_h_mcu = 7'd1;
    push_row(2, 0, fr, 0, 1'b1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 one sample short", 32'(out_valid), 32'd0);
    push(2, smpv(2, 15, 7, fr));
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 row complete", 32'(out_valid), 32'd1);
    chk(out_sol == 1'b1, "R4 first pixel", 32'(out_sol), 32'd1);
    recv_rows(2, 1, fr, 0, 0, 8);

    // R9, R7, R10: fill both strips under a stalled output
    fr++;
    cfg_w_mcu = 5'd1; cfg_h_mcu = 7'd2;
    push_row(1, 0, fr, 0, 1'b0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 second strip open", 32'(in_ready), 32'd1);
    push_row(1, 1, fr, 0, 1'b0);
    @(negedge clk);
    chk(in_ready == 1'b0, "R7 both full", 32'(in_ready), 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_blk = 2'(k % 3); in_sample = 8'hEE;
      chk(in_ready == 1'b0, "R7 ready held low", 32'(in_ready), 32'd0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    recv_rows(1, 2, fr, 2, 0, 8);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 strip released", 32'(in_ready), 32'd1);
    recv_rows(1, 2, fr, 0, 8, 16);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 no extra data", 32'(out_valid), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule